// File: doc/BRIEF.md
# GPIO Port Register Block

A 32-pin general-purpose I/O port controlled through three word registers on a simple 32-bit register bus. Software picks, per pin, whether the pin is an input or an output and whether an output drives push-pull or only pulls low. A third register holds the output values. The block turns these settings into a per-pin pad output-enable and a pad output-value. It also samples the pad inputs through two flip-flops and returns them on reads of the data register.

Register bits are numbered in reverse of pin numbers, so pin 0 is the most significant bit of every register. The data register keeps whatever software last wrote, whatever the direction. Software can therefore change a single pin with a read-modify-write of the stored value, even when some outputs are released open-drain lines that read back high. A build-time option makes the top four pins input-only.

Top module: `gpio_port_regs`

## Requirements
- R1: While rst_ni is low and after it rises, the direction, open-drain and data registers are all zero: every pin is an input, none is open-drain, and pad_oe_o and pad_out_o are all zero.
- R2: A write happens on a rising clock edge when req_i and we_i are both high. addr_i is a byte address compared in full: 0x0 selects direction, 0x4 selects open-drain and 0x8 selects data. rdata_o is combinational from addr_i. Any other address reads 0 and a write to it changes nothing. A write with req_i low changes nothing.
- R3: Pin n corresponds to register bit 31-n in every register. Pad vectors are indexed by pin number, so pad bit n is pin n.
- R4: A pin whose direction bit is 1 and whose open-drain bit is 0 has pad_oe_o high, and its pad_out_o equals its data bit.
- R5: A pin whose direction bit is 1 and whose open-drain bit is 1 drives low (pad_oe_o=1, pad_out_o=0) when its data bit is 0. It is released (pad_oe_o=0) when its data bit is 1. pad_out_o is never 1 on such a pin.
- R6: An input pin has pad_oe_o=0 and pad_out_o=0. Its data read bit is the pad level as sampled two rising edges earlier, through two flip-flops that reset to 0.
- R7: On a data read, an output pin returns its stored data bit, not the pad level.
- R8: The data register stores all 32 written bits regardless of direction. A value written while a pin is an input appears on the pad once the pin is made an output.
- R9: With INPUT_ONLY_TOP=1, pins 28 to 31 (register bits 3..0) can never become outputs: their direction bits store and read 0, and their pad_oe_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pad_in_i | input | 32 | Pad input levels, bit n is pin n |
| pad_oe_o | output | 32 | Pad output enable, bit n is pin n |
| pad_out_o | output | 32 | Pad output value, bit n is pin n |

## Verification
The pads are modelled as resolved lines with a pull-up and an external driver that the bench can turn on for each pin. The port is exercised in several ways:
- A single output on pin 0 shows whether the bit order is reversed correctly.
- An alternating data word over a mix of push-pull and open-drain pins separates driving from releasing.
- Stepping the external drivers one edge at a time measures the input latency exactly.
- Writing data while every pin is an input, then turning the pins to outputs, shows that the latch is independent of direction.
- Writing all ones to the direction register exposes the input-only pins.
- Accesses to an unmapped address, and writes without a request, show that they leave every register unchanged.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] DIR_OFF = 4'h0;
  localparam logic [ADDR_W-1:0] ODR_OFF = 4'h4;
  localparam logic [ADDR_W-1:0] DAT_OFF = 4'h8;

  typedef enum logic [1:0] {
    SEL_DIR,
    SEL_ODR,
    SEL_DAT,
    SEL_NONE
  } reg_sel_e;

  // pin order <-> register order
  function automatic logic [DW-1:0] bit_rev(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned W              = 32,
  parameter bit          INPUT_ONLY_TOP = 1'b0,
  parameter int unsigned INONLY_PINS    = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_dir_i,
  input  logic         wr_odr_i,
  input  logic         wr_dat_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] odr_o,
  output logic [W-1:0] dat_o
);
  logic [W-1:0] dir_wmask;

  // highest pins sit in the lowest register bits
  for (genvar b = 0; b < W; b++) begin : g_mask
    if (INPUT_ONLY_TOP && (b < INONLY_PINS)) begin : g_fixed
      assign dir_wmask[b] = 1'b0;
    end else begin : g_free
      assign dir_wmask[b] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      odr_o <= '0;
      dat_o <= '0;
    end else begin
      if (wr_dir_i) dir_o <= wdata_i & dir_wmask;
      if (wr_odr_i) odr_o <= wdata_i;
      if (wr_dat_i) dat_o <= wdata_i;
    end
  end
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] odr_i,
  input  logic [W-1:0] dat_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o
);
  for (genvar n = 0; n < W; n++) begin : g_pin
    localparam int unsigned RB = W - 1 - n;
    // open-drain: drive low on 0, release on 1
    assign oe_o[n]  = dir_i[RB] & (~odr_i[RB] | ~dat_i[RB]);
    assign out_o[n] = dir_i[RB] & ~odr_i[RB] & dat_i[RB];
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter bit          INPUT_ONLY_TOP = 1'b0,
  parameter int unsigned INONLY_PINS    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     pad_in_i,
  output logic [DW-1:0]     pad_oe_o,
  output logic [DW-1:0]     pad_out_o
);
  reg_sel_e      sel;
  logic          wr_en;
  logic [DW-1:0] dir_q, odr_q, dat_q;
  logic [DW-1:0] pin_sync, in_reg;

  always_comb begin
    unique case (addr_i)
      DIR_OFF: sel = SEL_DIR;
      ODR_OFF: sel = SEL_ODR;
      DAT_OFF: sel = SEL_DAT;
      default: sel = SEL_NONE;
    endcase
  end

  assign wr_en = req_i & we_i;

  gpio_regs #(
    .W             (DW),
    .INPUT_ONLY_TOP(INPUT_ONLY_TOP),
    .INONLY_PINS   (INONLY_PINS)
  ) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_dir_i(wr_en && sel == SEL_DIR),
    .wr_odr_i(wr_en && sel == SEL_ODR),
    .wr_dat_i(wr_en && sel == SEL_DAT),
    .wdata_i (wdata_i),
    .dir_o   (dir_q),
    .odr_o   (odr_q),
    .dat_o   (dat_q)
  );

  gpio_sync #(.W(DW)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_sync)
  );

  assign in_reg = bit_rev(pin_sync);

  gpio_pad_drv #(.W(DW)) drv_i (
    .dir_i(dir_q),
    .odr_i(odr_q),
    .dat_i(dat_q),
    .oe_o (pad_oe_o),
    .out_o(pad_out_o)
  );

  always_comb begin
    unique case (sel)
      SEL_DIR: rdata_o = dir_q;
      SEL_ODR: rdata_o = odr_q;
      SEL_DAT: rdata_o = (dir_q & dat_q) | (~dir_q & in_reg);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_port_pkg::*;
#(
  parameter bit          INPUT_ONLY_TOP = 1'b0,
  parameter int unsigned INONLY_PINS    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [DW-1:0]     pad_in_i,
  input logic [DW-1:0]     pad_oe_o,
  input logic [DW-1:0]     pad_out_o,
  input logic [DW-1:0]     dir_q,
  input logic [DW-1:0]     odr_q,
  input logic [DW-1:0]     dat_q
);
  localparam logic [DW-1:0] FIXED_IN =
    INPUT_ONLY_TOP ? DW'((64'd1 << INONLY_PINS) - 64'd1) : '0;

  logic [1:0] edges_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edges_q <= '0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
  end

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == DIR_OFF) |=> (dir_q == ($past(wdata_i) & ~FIXED_IN))); // R2

  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == DIR_OFF) |=> $stable(dir_q)); // R2

  AST_OE_NEEDS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~bit_rev(dir_q)) == '0); // R3

  AST_PP_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_rev(dir_q & ~odr_q) & ~pad_oe_o) == '0); // R4

  AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_rev(odr_q) & pad_out_o) == '0); // R5

  AST_OD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_rev(dir_q & odr_q & dat_q) & pad_oe_o) == '0); // R5

  AST_IN_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q >= 2'd2 && addr_i == DAT_OFF) |->
      (((rdata_o ^ bit_rev($past(pad_in_i, 2))) & ~dir_q) == '0)); // R6

  AST_OUT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == DAT_OFF) |-> (((rdata_o ^ dat_q) & dir_q) == '0)); // R7

  AST_INONLY_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dir_q & FIXED_IN) == '0) && ((pad_oe_o & bit_rev(FIXED_IN)) == '0)); // R9
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .INPUT_ONLY_TOP(INPUT_ONLY_TOP),
  .INONLY_PINS   (INONLY_PINS)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pad_in_i (pad_in_i),
  .pad_oe_o (pad_oe_o),
  .pad_out_o(pad_out_o),
  .dir_q    (dir_q),
  .odr_q    (odr_q),
  .dat_q    (dat_q)
);

// File: tb/gpio_port_regs_tb_top.sv
module gpio_port_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req, we;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata, pad_in, pad_oe, pad_out;
  logic [31:0] ext_en, ext_val, pad_lvl;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  // pads: driven by dut, else by external driver, else pull-up
  always_comb begin
    for (int n = 0; n < 32; n++)
      pad_lvl[n] = pad_oe[n] ? pad_out[n] : (ext_en[n] ? ext_val[n] : 1'b1);
  end
  assign pad_in = pad_lvl;

  gpio_port_regs #(.INPUT_ONLY_TOP(1'b1), .INONLY_PINS(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_oe_o(pad_oe), .pad_out_o(pad_out)
  );

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // reference model, register bit order; s1/s2 in pin order
  logic [31:0] m_dir, m_od, m_dat, m_s1, m_s2;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_dir <= 0; m_od <= 0; m_dat <= 0; m_s1 <= 0; m_s2 <= 0;
    end else begin
      if (req && we) begin
        if (addr == 4'h0) m_dir <= {wdata[31:4], 4'b0000};
        if (addr == 4'h4) m_od  <= wdata;
        if (addr == 4'h8) m_dat <= wdata;
      end
      m_s1 <= pad_lvl;
      m_s2 <= m_s1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_ni && !done) begin
      logic [31:0] e_oe, e_out, e_rd;
      for (int n = 0; n < 32; n++) begin
        int r;
        r = 31 - n;
        e_oe[n]  = m_dir[r] && (!m_od[r] || !m_dat[r]);
        e_out[n] = m_dir[r] && !m_od[r] && m_dat[r];
      end
      case (addr)
        4'h0: e_rd = m_dir;
        4'h4: e_rd = m_od;
        4'h8: for (int r = 0; r < 32; r++) e_rd[r] = m_dir[r] ? m_dat[r] : m_s2[31-r];
        default: e_rd = 0;
      endcase
      chk("R4 R5 R6 R9 pad_oe", pad_oe, e_oe);
      chk("R3 R4 R5 pad_out", pad_out, e_out);
      chk("R2 R6 R7 rdata", rdata, e_rd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req = 0; we = 0; addr = 0; wdata = 0; ext_en = 0; ext_val = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pad_oe in reset", pad_oe, 32'h0);
    chk("R1 pad_out in reset", pad_out, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R1 dir after reset", 4'h0, 32'h0);
    rd_chk("R1 odr after reset", 4'h4, 32'h0);
    rd_chk("R6 pull-up read", 4'h8, 32'hFFFF_FFFF);

    // R3: pin 0 is the MSB
    wr(4'h0, 32'h8000_0000);
    #1 chk("R3 pin0 oe", pad_oe, 32'h0000_0001);
    wr(4'h8, 32'h8000_0000);
    #1 chk("R3 pin0 out", pad_out, 32'h0000_0001);

    // R9: top pins stay inputs
    wr(4'h0, 32'hFFFF_FFFF);
    rd_chk("R9 dir readback", 4'h0, 32'hFFFF_FFF0);
    chk("R9 top pins oe", pad_oe & 32'hF000_0000, 32'h0);

    // R4/R7: push-pull outputs
    wr(4'h8, 32'hA5A5_5A5A);
    #1 chk("R4 pad_out", pad_out, rev32(32'hA5A5_5A5A) & 32'h0FFF_FFFF);
    chk("R4 pad_oe", pad_oe, 32'h0FFF_FFFF);
    rd_chk("R7 data read", 4'h8, 32'hA5A5_5A5F);

    // R5: pins 0..15 open-drain
    wr(4'h4, 32'hFFFF_0000);
    #1 chk("R5 od out low", pad_out & 32'h0000_FFFF, 32'h0);
    chk("R5 od oe", pad_oe & 32'h0000_FFFF, ~rev32(32'hA5A5_5A5A) & 32'h0000_FFFF);
    rd_chk("R7 od read latch", 4'h8, 32'hA5A5_5A5F);

    // R8: latch independent of direction
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h1234_5678);
    #1 chk("R8 inputs not driven", pad_oe, 32'h0);
    rd_chk("R8 read pads", 4'h8, 32'hFFFF_FFFF);
    wr(4'h4, 32'h0);
    wr(4'h0, 32'hFFFF_FFF0);
    #1 chk("R8 stored value driven", pad_out, rev32(32'h1234_5678) & 32'h0FFF_FFFF);
    rd_chk("R8 latch read", 4'h8, 32'h1234_567F);

    // R6: two-edge input latency
    wr(4'h0, 32'h0);
    repeat (2) @(negedge clk);
    ext_en = 32'hFFFF_FFFF; ext_val = 32'h0;
    rd_chk("R6 before edge", 4'h8, 32'hFFFF_FFFF);
    @(negedge clk);
    rd_chk("R6 after one edge", 4'h8, 32'hFFFF_FFFF);
    @(negedge clk);
    rd_chk("R6 after two edges", 4'h8, 32'h0);
    ext_val = 32'h0F0F_3C3C;
    repeat (2) @(negedge clk);
    rd_chk("R6 pattern", 4'h8, rev32(32'h0F0F_3C3C));
    ext_en = 0;

    // R2: unmapped address and missing request
    wr(4'h4, 32'h00FF_00FF);
    wr(4'hC, 32'hDEAD_BEEF);
    rd_chk("R2 unmapped read", 4'hC, 32'h0);
    rd_chk("R2 odr kept", 4'h4, 32'h00FF_00FF);
    @(negedge clk);
    req = 1'b0; we = 1'b1; addr = 4'h4; wdata = 32'h1111_1111;
    @(negedge clk);
    we = 1'b0;
    rd_chk("R2 no req no write", 4'h4, 32'h00FF_00FF);
    rd_chk("R2 dir kept", 4'h0, 32'h0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule